// File: doc/BRIEF.md
# Edge-Triggered Converter Bus Controller

This block is the digital front end of a byte-wide sampling converter. It watches a chip-select, a read strobe and a write strobe, all active low, and turns their falling edges into a sample-hold command and a one-cycle conversion-start pulse for an external converter core. When the core returns its end-of-conversion pulse with a result and an over-range flag, the block latches both. It then pulls its interrupt output low. The latched values drive the bus data and over-range outputs, and an output-enable signal stands in for the three-state drivers.

A static mode input chooses how conversions start. In write-read mode, the write strobe starts a conversion and the read strobe only gates the outputs. Holding chip-select and read low gives free-running stand-alone operation, where the outputs stay enabled and change on each completed conversion. In read mode, the falling read strobe itself starts the conversion and the write pin turns into a ready output that the block pulls low until the result is in place. During that time the bus shows the previous result, and the new result replaces it on completion. After every conversion a recovery window, counted in clock cycles, must pass before another start is accepted. A start edge that comes too early is dropped, and a sticky flag records it.

Every strobe goes through a multi-flop synchronizer. All edges are found in the system clock domain, so a pin change takes effect SYNC_STAGES+1 clock edges after it is first sampled.

Top module: `adc_strobe_ctrl`

## Requirements
- R1: After reset, int_n is 1, and bus_oe, rdy_pull_low, conv_start, hold, start_err, over_range and bus_data are all 0.
- R2: While cs_n is high, bus_oe is 0 and falling or rising edges on rd_n and wr_n have no effect: no conv_start, no hold, and int_n keeps its value.
- R3: In write-read mode (mode_wr_rd = 1), a falling wr_n with cs_n low starts a conversion whatever the pulse width. conv_start is high for exactly one cycle, 3 clock edges after the falling edge is first sampled (2 synchronizer stages plus 1 register), and hold goes high in the same cycle and stays high until the end of conversion is accepted.
- R4: In read mode (mode_wr_rd = 0), a falling rd_n with cs_n low starts a conversion, and edges on wr_n start nothing. rdy_pull_low (1 = ready pin pulled low) rises together with conv_start and falls in the cycle after the end of conversion is accepted.
- R5: core_eoc accepted during hold loads core_data into bus_data and core_ovf into over_range on that edge. Both then hold until the next accepted end of conversion. In read mode, bus_data shows the old result while the conversion runs and the new result from the completion edge onward.
- R6: int_n goes to 0 in the cycle after an accepted end of conversion. It returns to 1 after a rising rd_n with cs_n low. In write-read mode it also returns to 1 when a write start is accepted.
- R7: When an end of conversion and a read release (rising rd_n with cs_n low) land on the same clock edge, the end of conversion wins and int_n is 0 afterwards.
- R8: bus_oe is 1 exactly when the synchronized cs_n and rd_n are both low. With both held low in write-read mode, bus_oe stays 1 through repeated conversions and bus_data takes each new result.
- R9: After an accepted end of conversion, starts are rejected for RECOV_CYCLES cycles. A start request evaluated on edge e+RECOV_CYCLES is dropped, and one evaluated on edge e+RECOV_CYCLES+1 is accepted, where e is the completion edge. A request during hold or recovery produces no conv_start and sets start_err, which stays 1 until reset.
- R10: core_eoc outside a conversion is ignored: bus_data, over_range and int_n keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_rd | input | 1 | Static mode select: 1 = write-read, 0 = read |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe input (used in write-read mode only) |
| rdy_pull_low | output | 1 | Ready pin pull-down enable in read mode (1 = pin low) |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| hold | output | 1 | Sample-hold command, high while converting |
| core_eoc | input | 1 | End-of-conversion pulse from the core |
| core_data | input | DATA_W | Conversion result from the core |
| core_ovf | input | 1 | Over-range flag from the core |
| bus_data | output | DATA_W | Latched result for the bus |
| bus_oe | output | 1 | Output enable for bus_data and over_range |
| over_range | output | 1 | Latched over-range flag |
| int_n | output | 1 | Active-low conversion-done interrupt |
| start_err | output | 1 | Sticky flag for start edges dropped while busy |

## Verification
Two functions can fall on one clock edge: the core's completion, which pulls int_n low, and a read release, which sets it high again. This is provoked in read mode by raising rd_n exactly two negative edges before the end-of-conversion pulse, so that the synchronized rising edge and the accepted completion share one posedge. It is judged correct when int_n is 0 after that edge and stays 0. The recovery boundary is handled the same way: start edges are placed so that the request is evaluated one edge before, and exactly on, the first idle edge.

// File: rtl/adc_ifc_pkg.sv
package adc_ifc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_CONV  = 2'd1,
      PH_RECOV = 2'd2
   } phase_t;

   localparam logic MODE_READ = 1'b0;
   localparam logic MODE_WRRD = 1'b1;

   localparam int PIN_CS   = 0;
   localparam int PIN_RD   = 1;
   localparam int PIN_WR   = 2;
   localparam int NUM_PINS = 3;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic level,
   output logic fall,
   output logic rise
);

   logic [STAGES-1:0] chain;
   logic              prev;

   initial begin : p_param_chk
      if (STAGES < 2) $fatal(1, "strobe_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], pin_n};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign fall  = prev & ~level;
   assign rise  = ~prev & level;

endmodule

// File: rtl/conv_phase.sv
module conv_phase
   import adc_ifc_pkg::*;
#(
   parameter int RECOV_CYCLES = 175
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic eoc,
   output logic start_acc,
   output logic eoc_acc,
   output logic conv_start,
   output logic hold,
   output logic start_err
);

   localparam int CNT_W = (RECOV_CYCLES < 2) ? 1 : $clog2(RECOV_CYCLES);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RECOV_CYCLES - 1);

   phase_t           ph;
   logic [CNT_W-1:0] cnt;

   initial begin : p_param_chk
      if (RECOV_CYCLES < 1) $fatal(1, "conv_phase: RECOV_CYCLES must be at least 1");
   end

   assign start_acc = start_req & (ph == PH_IDLE);
   assign eoc_acc   = eoc & (ph == PH_CONV);
   assign hold      = (ph == PH_CONV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph         <= PH_IDLE;
         cnt        <= '0;
         conv_start <= 1'b0;
         start_err  <= 1'b0;
      end else begin
         conv_start <= start_acc;
         if (start_req && (ph != PH_IDLE)) start_err <= 1'b1;
         case (ph)
            PH_IDLE: begin
               if (start_acc) ph <= PH_CONV;
            end
            PH_CONV: begin
               if (eoc) begin
                  ph  <= PH_RECOV;
                  cnt <= RELOAD;
               end
            end
            PH_RECOV: begin
               if (cnt == '0) ph <= PH_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/result_hold.sv
module result_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eoc_acc,
   input  logic [DATA_W-1:0] core_data,
   input  logic              core_ovf,
   input  logic              release_req,
   input  logic              arm_req,
   output logic [DATA_W-1:0] data_q,
   output logic              ovf_q,
   output logic              int_n
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ovf_q  <= 1'b0;
         int_n  <= 1'b1;
      end else if (eoc_acc) begin
         data_q <= core_data;
         ovf_q  <= core_ovf;
         int_n  <= 1'b0;
      end else if (release_req || arm_req) begin
         int_n  <= 1'b1;
      end
   end

endmodule

// File: rtl/adc_strobe_ctrl.sv
module adc_strobe_ctrl
   import adc_ifc_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int RECOV_CYCLES = 175,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr_rd,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   output logic              rdy_pull_low,
   output logic              conv_start,
   output logic              hold,
   input  logic              core_eoc,
   input  logic [DATA_W-1:0] core_data,
   input  logic              core_ovf,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_oe,
   output logic              over_range,
   output logic              int_n,
   output logic              start_err
);

   logic [NUM_PINS-1:0] pin_n;
   logic [NUM_PINS-1:0] lvl;
   logic [NUM_PINS-1:0] fall;
   logic [NUM_PINS-1:0] rise;

   logic cs_on;
   logic wr_mode;
   logic start_req;
   logic start_acc;
   logic eoc_acc;
   logic release_req;
   logic arm_req;
   logic unused_edges;

   initial begin : p_param_chk
      if (DATA_W < 1)       $fatal(1, "adc_strobe_ctrl: DATA_W must be positive");
      if (SYNC_STAGES < 2)  $fatal(1, "adc_strobe_ctrl: SYNC_STAGES must be at least 2");
      if (RECOV_CYCLES < 1) $fatal(1, "adc_strobe_ctrl: RECOV_CYCLES must be at least 1");
   end

   assign pin_n = {wr_n, rd_n, cs_n};

   generate
      for (genvar g = 0; g < NUM_PINS; g++) begin : g_sync
         strobe_sync #(
            .STAGES (SYNC_STAGES)
         ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_n (pin_n[g]),
            .level (lvl[g]),
            .fall  (fall[g]),
            .rise  (rise[g])
         );
      end
   endgenerate

   assign unused_edges = ^{fall[PIN_CS], rise[PIN_CS], lvl[PIN_WR], rise[PIN_WR]};

   assign cs_on       = ~lvl[PIN_CS];
   assign wr_mode     = (mode_wr_rd == MODE_WRRD);
   assign start_req   = cs_on & (wr_mode ? fall[PIN_WR] : fall[PIN_RD]);
   assign release_req = cs_on & rise[PIN_RD];
   assign arm_req     = start_acc & wr_mode;
   assign bus_oe      = cs_on & ~lvl[PIN_RD];

   conv_phase #(
      .RECOV_CYCLES (RECOV_CYCLES)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (start_req),
      .eoc        (core_eoc),
      .start_acc  (start_acc),
      .eoc_acc    (eoc_acc),
      .conv_start (conv_start),
      .hold       (hold),
      .start_err  (start_err)
   );

   result_hold #(
      .DATA_W (DATA_W)
   ) u_result (
      .clk         (clk),
      .rst_n       (rst_n),
      .eoc_acc     (eoc_acc),
      .core_data   (core_data),
      .core_ovf    (core_ovf),
      .release_req (release_req),
      .arm_req     (arm_req),
      .data_q      (bus_data),
      .ovf_q       (over_range),
      .int_n       (int_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_pull_low <= 1'b0;
      end else if (eoc_acc) begin
         rdy_pull_low <= 1'b0;
      end else if (start_acc && !wr_mode) begin
         rdy_pull_low <= 1'b1;
      end
   end

endmodule

// File: rtl/adc_ifc_chk.sv
module adc_ifc_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_wr_rd,
   input logic              conv_start,
   input logic              hold,
   input logic              core_eoc,
   input logic              int_n,
   input logic              rdy_pull_low,
   input logic              start_err,
   input logic [DATA_W-1:0] bus_data
);

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start); // R3

   AST_START_WITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> hold); // R3

   AST_RDY_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr_rd |-> !rdy_pull_low); // R4

   AST_RDY_INSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_pull_low |-> hold); // R4

   AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(hold && core_eoc) |=> $stable(bus_data)); // R5

   AST_INT_LOW_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && core_eoc) |=> !int_n); // R6

   AST_HOLD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && core_eoc) |=> !hold); // R9

   AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !conv_start); // R9

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      start_err |=> start_err); // R9

endmodule

bind adc_strobe_ctrl adc_ifc_chk #(
   .DATA_W (DATA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_wr_rd   (mode_wr_rd),
   .conv_start   (conv_start),
   .hold         (hold),
   .core_eoc     (core_eoc),
   .int_n        (int_n),
   .rdy_pull_low (rdy_pull_low),
   .start_err    (start_err),
   .bus_data     (bus_data)
);

// File: tb/test_adc_strobe_ctrl.sv
`timescale 1ns/1ps
module test_adc_strobe_ctrl;

   localparam int DW        = 8;
   localparam int RC        = 175;
   localparam int CONV_WAIT = 625;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_wr_rd = 1'b1;
   logic          cs_n = 1'b1;
   logic          rd_n = 1'b1;
   logic          wr_n = 1'b1;
   logic          core_eoc = 1'b0;
   logic [DW-1:0] core_data = '0;
   logic          core_ovf = 1'b0;
   logic          rdy_pull_low, conv_start, hold, bus_oe, over_range, int_n, start_err;
   logic [DW-1:0] bus_data;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   adc_strobe_ctrl #(
      .DATA_W       (DW),
      .RECOV_CYCLES (RC),
      .SYNC_STAGES  (2)
   ) i_adc_strobe_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_wr_rd   (mode_wr_rd),
      .cs_n         (cs_n),
      .rd_n         (rd_n),
      .wr_n         (wr_n),
      .rdy_pull_low (rdy_pull_low),
      .conv_start   (conv_start),
      .hold         (hold),
      .core_eoc     (core_eoc),
      .core_data    (core_data),
      .core_ovf     (core_ovf),
      .bus_data     (bus_data),
      .bus_oe       (bus_oe),
      .over_range   (over_range),
      .int_n        (int_n),
      .start_err    (start_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic nc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst_n = 1'b0; mode_wr_rd = mode;
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; core_eoc = 1'b0;
      nc(3);
      rst_n = 1'b1;
      nc(4);
   endtask

   task automatic pulse_eoc(input logic [DW-1:0] d, input logic ov);
      core_eoc = 1'b1; core_data = d; core_ovf = ov;
      nc(1);
      core_eoc = 1'b0;
   endtask

   // falling write edge of one cycle, left three negedges later (conv_start visible)
   task automatic wr_start;
      wr_n = 1'b0;
      nc(1);
      wr_n = 1'b1;
      nc(2);
   endtask

   task automatic t_reset;
      do_reset(1'b1);
      chk("R1 int_n", 32'(int_n), 32'd1);
      chk("R1 bus_oe", 32'(bus_oe), 32'd0);
      chk("R1 rdy", 32'(rdy_pull_low), 32'd0);
      chk("R1 conv_start/hold", 32'({conv_start, hold}), 32'd0);
      chk("R1 start_err", 32'(start_err), 32'd0);
      chk("R1 bus_data/ovf", 32'({bus_data, over_range}), 32'd0);
   endtask

   task automatic t_wr_basic;
      do_reset(1'b1);
      cs_n = 1'b0; nc(4);
      wr_n = 1'b0; nc(1); wr_n = 1'b1; nc(1);
      chk("R3 no start before sync", 32'(conv_start), 32'd0);
      nc(1);
      chk("R3 conv_start edge", 32'({conv_start, hold}), 32'd3);
      nc(1);
      chk("R3 start one cycle, hold kept", 32'({conv_start, hold}), 32'd1);
      nc(CONV_WAIT);
      chk("R3 hold during conversion", 32'(hold), 32'd1);
      pulse_eoc(8'hA5, 1'b0);
      chk("R5 data latched", 32'(bus_data), 32'hA5);
      chk("R6 int low on done", 32'(int_n), 32'd0);
      chk("R8 oe off with read high", 32'(bus_oe), 32'd0);
      rd_n = 1'b0; nc(3);
      chk("R8 oe on for read", 32'({bus_oe, bus_data}), 32'h1A5);
      rd_n = 1'b1; nc(3);
      chk("R6 int high after read", 32'(int_n), 32'd1);
      nc(RC);
      // long write pulse: width must not matter
      wr_n = 1'b0; nc(3);
      chk("R3 long write starts", 32'(conv_start), 32'd1);
      nc(50); wr_n = 1'b1; nc(10);
      chk("R3 hold independent of width", 32'(hold), 32'd1);
      pulse_eoc(8'h3C, 1'b1);
      chk("R5 over-range latched", 32'({bus_data, over_range}), 32'h79);
      chk("R6 int low again", 32'(int_n), 32'd0);
      nc(RC + 5);
      wr_start();
      chk("R6 write start sets int", 32'({int_n, conv_start}), 32'd3);
      chk("R5 old data kept during conversion", 32'(bus_data), 32'h3C);
      nc(10);
      pulse_eoc(8'h11, 1'b0);
      chk("R5 third result", 32'({bus_data, over_range}), 32'h22);
   endtask

   task automatic t_eoc_idle;
      rd_n = 1'b0; nc(2); rd_n = 1'b1; nc(3);
      chk("R10 int released", 32'(int_n), 32'd1);
      nc(RC + 5);
      pulse_eoc(8'hFF, 1'b1);
      nc(2);
      chk("R10 data unchanged", 32'({bus_data, over_range}), 32'h22);
      chk("R10 int unchanged", 32'(int_n), 32'd1);
   endtask

   task automatic t_cs_ignored;
      logic seen;
      do_reset(1'b1);
      cs_n = 1'b0; nc(4);
      wr_start();
      nc(5);
      pulse_eoc(8'h42, 1'b0);
      cs_n = 1'b1;
      nc(RC + 5);
      seen = 1'b0;
      rd_n = 1'b0; wr_n = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (i == 1) begin rd_n = 1'b1; wr_n = 1'b1; end
         seen = seen | conv_start | hold | bus_oe;
      end
      chk("R2 no start/oe with cs high", 32'(seen), 32'd0);
      chk("R2 int unchanged with cs high", 32'(int_n), 32'd0);
      chk("R2 no error from ignored edge", 32'(start_err), 32'd0);
   endtask

   task automatic t_recovery;
      logic seen;
      do_reset(1'b1);
      cs_n = 1'b0; nc(4);
      wr_start();
      nc(10);
      pulse_eoc(8'h01, 1'b0);
      // request evaluated on edge e+RC+1: accepted
      nc(RC - 2);
      wr_n = 1'b0; nc(2);
      chk("R9 not yet started", 32'(conv_start), 32'd0);
      nc(1);
      chk("R9 first idle edge accepts", 32'(conv_start), 32'd1);
      wr_n = 1'b1; nc(5);
      chk("R9 no error so far", 32'(start_err), 32'd0);
      // start during conversion
      seen = 1'b0;
      wr_n = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (i == 0) wr_n = 1'b1;
         seen = seen | conv_start;
      end
      chk("R9 busy start dropped", 32'(seen), 32'd0);
      chk("R9 start_err set", 32'(start_err), 32'd1);
      pulse_eoc(8'h02, 1'b0);
      // request evaluated on edge e+RC: dropped
      nc(RC - 3);
      seen = 1'b0;
      wr_n = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (i == 0) wr_n = 1'b1;
         seen = seen | conv_start | hold;
      end
      chk("R9 last recovery edge drops", 32'(seen), 32'd0);
      chk("R9 start_err sticky", 32'(start_err), 32'd1);
   endtask

   task automatic t_read_mode;
      logic seen;
      do_reset(1'b0);
      cs_n = 1'b0; nc(4);
      rd_n = 1'b0; nc(3);
      chk("R4 read starts, ready low", 32'({conv_start, rdy_pull_low, hold}), 32'd7);
      chk("R5 old data shown", 32'({bus_oe, bus_data}), 32'h100);
      nc(CONV_WAIT);
      chk("R4 ready held", 32'(rdy_pull_low), 32'd1);
      pulse_eoc(8'h5A, 1'b0);
      chk("R4 ready released", 32'(rdy_pull_low), 32'd0);
      chk("R5 new data in place", 32'({bus_oe, bus_data}), 32'h15A);
      rd_n = 1'b1; nc(3);
      chk("R6 read release", 32'(int_n), 32'd1);
      nc(RC);
      seen = 1'b0;
      wr_n = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (i == 0) wr_n = 1'b1;
         seen = seen | conv_start | hold | rdy_pull_low;
      end
      chk("R4 write ignored in read mode", 32'(seen), 32'd0);
      rd_n = 1'b0; nc(3);
      chk("R5 previous result on read", 32'({rdy_pull_low, bus_data}), 32'h15A);
      nc(20);
      pulse_eoc(8'hC3, 1'b0);
      chk("R5 replaced on completion", 32'({bus_oe, bus_data}), 32'h1C3);
      rd_n = 1'b1; nc(3);
   endtask

   task automatic t_same_cycle;
      do_reset(1'b0);
      cs_n = 1'b0; nc(4);
      rd_n = 1'b0; nc(3);
      chk("R7 conversion begun", 32'(hold), 32'd1);
      nc(30);
      rd_n = 1'b1; nc(2);
      pulse_eoc(8'h77, 1'b0);
      chk("R7 done beats release", 32'(int_n), 32'd0);
      nc(5);
      chk("R7 int stays low", 32'({int_n, bus_data}), 32'h077);
   endtask

   task automatic t_standalone;
      int drops;
      logic [DW-1:0] v;
      do_reset(1'b1);
      cs_n = 1'b0; rd_n = 1'b0; nc(4);
      drops = 0;
      for (int k = 0; k < 3; k++) begin
         v = DW'(8'h20 + k * 8'h31);
         wr_n = 1'b0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i == 0) wr_n = 1'b1;
            if (!bus_oe) drops++;
         end
         pulse_eoc(v, 1'b0);
         chk("R8 standalone data", 32'(bus_data), 32'(v));
         for (int i = 0; i < RC + 5; i++) begin
            @(negedge clk);
            if (!bus_oe) drops++;
         end
      end
      chk("R8 outputs never disabled", 32'(drops), 32'd0);
   endtask

   initial begin : p_watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : p_main
      t_reset();
      t_wr_basic();
      t_eoc_idle();
      t_cs_ignored();
      t_recovery();
      t_read_mode();
      t_same_cycle();
      t_standalone();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule